// File: doc/BRIEF.md
# 8-bit accumulator processor core

A small stored-program machine with one unified memory of 256 bytes for code and data. The working registers are an 8-bit accumulator with a one-bit carry flag, an opcode register, an operand/address register and an 8-bit program counter. Every instruction is two bytes long: an opcode and an argument. A hard-wired three-phase controller fetches the opcode, then the argument, and then executes. The controller decodes only the opcode register. ALU results and the carry never steer the sequence, so no branch depends on a flag.

The next program counter is either the incremented value or the argument register. The memory address is either the program counter, during both fetch phases, or the argument register, for data accesses. The memory lives inside the block. A load port fills it while reset is held. Debug outputs show the program counter, the accumulator, the carry and the phase. A debug read port returns any memory byte combinationally.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, the accumulator, the carry and the phase all become 0, and `dbg_state` reads 0.
- R2: After reset the phase cycles 0 (opcode fetch), 1 (argument fetch), 2 (execute), then back to 0, one phase per clock. The program counter rises by 1 in each of the two fetch phases.
- R3: Any opcode with bit 7 set loads the program counter with the argument byte in its execute phase.
- R4: An opcode whose high nibble is 0x4 writes the accumulator into memory at the argument byte. The accumulator and the carry are left unchanged.
- R5: An opcode whose high nibble is 0x1 writes accumulator := f(acc, arg), where f is the low nibble of the opcode. The functions are:
  - 0: acc
  - 1: acc+arg
  - 2: acc-arg
  - 3: AND
  - 4: OR
  - 5: XOR
  - 6: NOT acc
  - 7: shift left
  - 8: shift right (logical)
  - 9: arg
  - A: acc+1
  - B: acc-1
  - C: 0-acc
  - D: 0x00
  - E: 0xFF
  - F: 0x01
- R6: An opcode whose high nibble is 0x0 applies the same sixteen functions, with the operand read from memory at the argument byte. For example, 0x0F loads 1 and 0x0A increments.
- R7: Every ALU opcode also writes the carry. The carry is the carry-out for functions 1 and A. It is the borrow (acc<operand) for 2, acc==0 for B, and acc!=0 for C. It is the bit shifted out for 7 and 8. It is 0 for all other functions.
- R8: Opcodes with a high nibble of 0x2, 0x3, 0x5, 0x6 or 0x7 leave the accumulator, the carry and the memory unchanged.
- R9: When `ld_en` is high at a clock edge, `ld_data` is written to memory at `ld_addr`. `dbg_rd_data` always shows memory at `dbg_rd_addr`.
- R10: The program 0F 00, 0A 00, 48 20, 80 02 leaves 1+N modulo 256 at address 0x20 after its N-th store. The store happens at clock 9N after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | 8 | Memory load address |
| ld_data | input | 8 | Memory load data |
| dbg_rd_addr | input | 8 | Debug memory read address |
| dbg_rd_data | output | 8 | Memory byte at dbg_rd_addr |
| dbg_pc | output | 8 | Program counter |
| dbg_acc | output | 8 | Accumulator |
| dbg_cy | output | 1 | Carry flag |
| dbg_state | output | 2 | Controller phase |

## Verification
The assertions take for granted that `rst` is high from time zero until the first edge. They also assume that `ld_en` is raised only while the core is held in reset, so a load never meets a core store. The stimulus honours both assumptions: every program is written during reset, and reset is released at a falling edge only after `ld_en` has dropped. The bench reads back only memory addresses it has written itself.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
    localparam int WORD_W = 8;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        PH_OPC = 2'd0,
        PH_ARG = 2'd1,
        PH_EXE = 2'd2
    } phase_e;

    typedef struct packed {
        logic ir_we;
        logic ar_we;
        logic pc_inc;
        logic pc_load;
        logic addr_ar;
        logic acc_we;
        logic mem_we;
        logic opd_mem;
    } ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] ar;
        logic [WORD_W-1:0] acc;
        logic              cy;
    } dp_t;
endpackage

// File: rtl/acc8_alu.sv
module acc8_alu #(
    parameter int W = 8
) (
    input  logic [3:0]   fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide = '0;
        y    = '0;
        cout = 1'b0;
        case (fn)
            4'h0: y = a;
            4'h1: begin
                wide = {1'b0, a} + {1'b0, b};
                y    = wide[W-1:0];
                cout = wide[W];
            end
            4'h2: begin
                y    = a - b;
                cout = (a < b);
            end
            4'h3: y = a & b;
            4'h4: y = a | b;
            4'h5: y = a ^ b;
            4'h6: y = ~a;
            4'h7: begin
                y    = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            4'h8: begin
                y    = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            4'h9: y = b;
            4'hA: begin
                wide = {1'b0, a} + {{W{1'b0}}, 1'b1};
                y    = wide[W-1:0];
                cout = wide[W];
            end
            4'hB: begin
                y    = a - W'(1);
                cout = (a == '0);
            end
            4'hC: begin
                y    = '0 - a;
                cout = (a != '0);
            end
            4'hD: y = '0;
            4'hE: y = '1;
            default: y = W'(1);
        endcase
    end
endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
    import acc8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] opc,
    output phase_e            phase,
    output ctl_t              ctl
);
    phase_e phase_d, phase_q;

    always_comb begin
        ctl     = '0;
        phase_d = phase_q;
        case (phase_q)
            PH_OPC: begin
                ctl.ir_we  = 1'b1;
                ctl.pc_inc = 1'b1;
                phase_d    = PH_ARG;
            end
            PH_ARG: begin
                ctl.ar_we  = 1'b1;
                ctl.pc_inc = 1'b1;
                phase_d    = PH_EXE;
            end
            PH_EXE: begin
                phase_d = PH_OPC;
                if (opc[WORD_W-1]) begin
                    ctl.pc_load = 1'b1;
                end else begin
                    case (opc[WORD_W-2:WORD_W-4])
                        3'b100: begin
                            ctl.mem_we  = 1'b1;
                            ctl.addr_ar = 1'b1;
                        end
                        3'b000: begin
                            ctl.acc_we  = 1'b1;
                            ctl.opd_mem = 1'b1;
                            ctl.addr_ar = 1'b1;
                        end
                        3'b001: ctl.acc_we = 1'b1;
                        default: ;
                    endcase
                end
            end
            default: phase_d = PH_OPC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_OPC;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    AST_OPC_TO_ARG: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_OPC) |=> (phase_q == PH_ARG));  // R2
    AST_ARG_TO_EXE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ARG) |=> (phase_q == PH_EXE));  // R2
    AST_EXE_TO_OPC: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXE) |=> (phase_q == PH_OPC));  // R2
endmodule

// File: rtl/acc8_mem.sv
module acc8_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en)   cell_q[ld_addr] <= ld_data;
        else if (we) cell_q[addr]    <= wdata;
    end

    assign rdata     = cell_q[addr];
    assign dbg_rdata = cell_q[dbg_addr];

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && !ld_en) |=> (cell_q[$past(addr)] == $past(wdata)));  // R4
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] dbg_rd_addr,
    output logic [WORD_W-1:0] dbg_rd_data,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [WORD_W-1:0] dbg_acc,
    output logic              dbg_cy,
    output logic [1:0]        dbg_state
);
    dp_t               dp_d, dp_q;
    ctl_t              ctl;
    phase_e            phase;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] alu_b;
    logic [WORD_W-1:0] alu_y;
    logic              alu_c;

    acc8_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .opc   (dp_q.ir),
        .phase (phase),
        .ctl   (ctl)
    );

    assign mem_addr = ctl.addr_ar ? dp_q.ar : dp_q.pc;

    acc8_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .we        (ctl.mem_we),
        .addr      (mem_addr),
        .wdata     (dp_q.acc),
        .rdata     (mem_rdata),
        .dbg_addr  (dbg_rd_addr),
        .dbg_rdata (dbg_rd_data)
    );

    assign alu_b = ctl.opd_mem ? mem_rdata : dp_q.ar;

    acc8_alu #(.W(WORD_W)) u_alu (
        .fn   (dp_q.ir[3:0]),
        .a    (dp_q.acc),
        .b    (alu_b),
        .y    (alu_y),
        .cout (alu_c)
    );

    always_comb begin
        dp_d = dp_q;
        if (ctl.ir_we)   dp_d.ir = mem_rdata;
        if (ctl.ar_we)   dp_d.ar = mem_rdata;
        if (ctl.pc_inc)  dp_d.pc = dp_q.pc + ADDR_W'(1);
        if (ctl.pc_load) dp_d.pc = ADDR_W'(dp_q.ar);
        if (ctl.acc_we) begin
            dp_d.acc = alu_y;
            dp_d.cy  = alu_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign dbg_pc    = dp_q.pc;
    assign dbg_acc   = dp_q.acc;
    assign dbg_cy    = dp_q.cy;
    assign dbg_state = phase;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPC || phase == PH_ARG)
        |=> (dp_q.pc == ADDR_W'($past(dp_q.pc) + ADDR_W'(1))));  // R2
    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXE && dp_q.ir[7]) |=> (dp_q.pc == $past(dp_q.ar)));  // R3
    AST_STORE_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXE && dp_q.ir[7:4] == 4'h4)
        |=> ($stable(dp_q.acc) && $stable(dp_q.cy)));  // R4
    AST_IDLE_GROUP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXE && !dp_q.ir[7] && dp_q.ir[6:4] inside {3'd2, 3'd3, 3'd5, 3'd6, 3'd7})
        |=> ($stable(dp_q.acc) && $stable(dp_q.cy)));  // R8
endmodule

// File: tb/acc8_core_bench.sv
`timescale 1ns/1ps
module acc8_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] dbg_rd_addr = '0;
    logic [7:0] dbg_rd_data, dbg_pc, dbg_acc;
    logic       dbg_cy;
    logic [1:0] dbg_state;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    acc8_core u_acc8_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .dbg_rd_addr(dbg_rd_addr), .dbg_rd_data(dbg_rd_data), .dbg_pc(dbg_pc),
        .dbg_acc(dbg_acc), .dbg_cy(dbg_cy), .dbg_state(dbg_state)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] ref_alu(input logic [3:0] f, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        case (f)
            4'h0: s = {1'b0, a};
            4'h1: s = {1'b0, a} + {1'b0, b};
            4'h2: s = {a < b, 8'(a - b)};
            4'h3: s = {1'b0, a & b};
            4'h4: s = {1'b0, a | b};
            4'h5: s = {1'b0, a ^ b};
            4'h6: s = {1'b0, ~a};
            4'h7: s = {a[7], a[6:0], 1'b0};
            4'h8: s = {a[0], 1'b0, a[7:1]};
            4'h9: s = {1'b0, b};
            4'hA: s = {1'b0, a} + 9'd1;
            4'hB: s = {a == 8'd0, 8'(a - 8'd1)};
            4'hC: s = {a != 8'd0, 8'(8'd0 - a)};
            4'hD: s = 9'h000;
            4'hE: s = 9'h0FF;
            default: s = 9'h001;
        endcase
        return s;
    endfunction

    task automatic put(input logic [7:0] a, input logic [7:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic release_run();
        ld_en = 1'b0;
        rst = 1'b0;
        edges = 0;
    endtask

    task automatic adv(input int target);
        repeat (target - edges) @(posedge clk);
        @(negedge clk);
        edges = target;
    endtask

    function automatic logic [7:0] peek_now();
        return dbg_rd_data;
    endfunction

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        dbg_rd_addr = a;
        #1;
        v = dbg_rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hold_reset();
        chk("R1 pc", 16'(dbg_pc), 16'h00);
        chk("R1 acc", 16'(dbg_acc), 16'h00);
        chk("R1 cy", 16'(dbg_cy), 16'h0);
        chk("R1 state", 16'(dbg_state), 16'h0);
        for (int i = 0; i < 256; i++) put(8'(i), 8'h00);
        put(8'h10, 8'hA5);
        peek(8'h10, v);
        chk("R9 load", 16'(v), 16'hA5);
    endtask

    task automatic t_phases();
        hold_reset();
        put(8'h00, 8'h19); put(8'h01, 8'h33);
        put(8'h02, 8'h80); put(8'h03, 8'h02);
        release_run();
        adv(1);
        chk("R2 state e1", 16'(dbg_state), 16'h1);
        chk("R2 pc e1", 16'(dbg_pc), 16'h01);
        adv(2);
        chk("R2 state e2", 16'(dbg_state), 16'h2);
        chk("R2 pc e2", 16'(dbg_pc), 16'h02);
        adv(3);
        chk("R2 state e3", 16'(dbg_state), 16'h0);
        chk("R2 pc e3", 16'(dbg_pc), 16'h02);
        chk("R5 imm load", 16'(dbg_acc), 16'h33);
        adv(6);
        chk("R3 self branch", 16'(dbg_pc), 16'h02);
        hold_reset();
        chk("R1 mid-run acc", 16'(dbg_acc), 16'h00);
        chk("R1 mid-run pc", 16'(dbg_pc), 16'h00);
    endtask

    task automatic t_branch();
        hold_reset();
        put(8'h00, 8'hC3); put(8'h01, 8'h33);
        put(8'h33, 8'h80); put(8'h34, 8'hF0);
        release_run();
        adv(3);
        chk("R3 branch C3", 16'(dbg_pc), 16'h33);
        adv(6);
        chk("R3 branch 80", 16'(dbg_pc), 16'hF0);
    endtask

    task automatic t_alu(input logic [3:0] f, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] e;
        logic [7:0] v;
        e = ref_alu(f, a, b);
        hold_reset();
        put(8'h40, 8'h00);
        put(8'h00, 8'h19); put(8'h01, a);
        put(8'h02, {4'h1, f}); put(8'h03, b);
        put(8'h04, 8'h48); put(8'h05, 8'h40);
        put(8'h06, 8'h80); put(8'h07, 8'h06);
        release_run();
        adv(6);
        chk($sformatf("R5 acc f=%h a=%h b=%h", f, a, b), 16'(dbg_acc), 16'(e[7:0]));
        chk($sformatf("R7 cy f=%h a=%h b=%h", f, a, b), 16'(dbg_cy), 16'(e[8]));
        adv(9);
        peek(8'h40, v);
        chk("R4 store", 16'(v), 16'(e[7:0]));
        chk("R4 acc kept", 16'(dbg_acc), 16'(e[7:0]));
    endtask

    task automatic t_mem_opd();
        logic [7:0] v;
        hold_reset();
        put(8'h50, 8'hF0); put(8'h41, 8'h00);
        put(8'h00, 8'h19); put(8'h01, 8'h20);
        put(8'h02, 8'h01); put(8'h03, 8'h50);
        put(8'h04, 8'h48); put(8'h05, 8'h41);
        put(8'h06, 8'h80); put(8'h07, 8'h06);
        release_run();
        adv(6);
        chk("R6 mem add", 16'(dbg_acc), 16'h10);
        chk("R7 mem add carry", 16'(dbg_cy), 16'h1);
        adv(9);
        peek(8'h41, v);
        chk("R6 stored", 16'(v), 16'h10);
    endtask

    task automatic t_idle();
        logic [7:0] v;
        hold_reset();
        put(8'h40, 8'h77);
        put(8'h00, 8'h19); put(8'h01, 8'hFF);
        put(8'h02, 8'h1A); put(8'h03, 8'h00);
        put(8'h04, 8'h65); put(8'h05, 8'h40);
        put(8'h06, 8'h37); put(8'h07, 8'h40);
        put(8'h08, 8'h80); put(8'h09, 8'h08);
        release_run();
        adv(6);
        chk("R7 inc wrap cy", 16'(dbg_cy), 16'h1);
        adv(12);
        chk("R8 acc", 16'(dbg_acc), 16'h00);
        chk("R8 cy", 16'(dbg_cy), 16'h1);
        peek(8'h40, v);
        chk("R8 mem", 16'(v), 16'h77);
    endtask

    task automatic t_demo();
        logic [7:0] v;
        int ns [6] = '{1, 2, 5, 255, 256, 300};
        hold_reset();
        put(8'h20, 8'h00);
        put(8'h00, 8'h0F); put(8'h01, 8'h00);
        put(8'h02, 8'h0A); put(8'h03, 8'h00);
        put(8'h04, 8'h48); put(8'h05, 8'h20);
        put(8'h06, 8'h80); put(8'h07, 8'h02);
        release_run();
        foreach (ns[k]) begin
            adv(9 * ns[k]);
            peek(8'h20, v);
            chk($sformatf("R10 N=%0d", ns[k]), 16'(v), 16'((1 + ns[k]) % 256));
            if (ns[k] == 255) chk("R7 wrap carry", 16'(dbg_cy), 16'h1);
            if (ns[k] == 256) chk("R7 carry cleared", 16'(dbg_cy), 16'h0);
        end
    endtask

    initial begin
        logic [7:0] as [4] = '{8'h3C, 8'hFF, 8'h00, 8'h81};
        logic [7:0] bs [4] = '{8'h0F, 8'h01, 8'h01, 8'h80};
        t_reset();
        t_phases();
        t_branch();
        for (int f = 0; f < 16; f++)
            for (int p = 0; p < 4; p++)
                t_alu(4'(f), as[p], bs[p]);
        t_mem_opd();
        t_idle();
        t_demo();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule